// File: doc/BRIEF.md
# Pixel-to-Parallel-Bus Packer

The packer sits between a pixel stream and the data lines of a parallel display bus that is 8, 9, 12 or 16 lines wide. It cuts each pixel into bus words. A pixel is 12, 16, 18 or 24 bits wide and the most significant bits go out first. The block also supports a fractional layout in which two pixels share three bus cycles. Each bus word goes to a separate strobe-timing engine through a valid/ready handshake. A data/command select line marks every word as either a command or data.

An update starts with a one-cycle `start` pulse that carries the pixel count, normally width times height. The block takes exactly that many pixels and sends the resulting words. It then raises `frame_done` for one cycle and goes back to idle. While idle, the block passes single command or parameter words straight through to the bus. The configuration is decoded all the time onto `fmt_code` and `cfg_err`, and the block latches it at `start`.

Top module: `pix_bus_packer`

## Requirements
- R1: `fmt_code` reports the cycles-per-pixel layout for the live `bus_code` (0:8, 1:9, 2:12, 3:16 lines) and `pix_code` (0:12, 1:16, 2:18, 3:24 bits). If pixel bits divided by lines is a whole number k from 1 to 3, the code is k-1. Otherwise, if twice the pixel bits divided by lines equals exactly 3, the code is 3 (two pixels in three cycles). Every other pair raises `cfg_err`.
- R2: With one cycle per pixel, the whole pixel goes out in a single word, for example 16 bits on 16 lines or 12 bits on 12 lines.
- R3: With two cycles per pixel, the upper half goes first and the lower half second. A 16-bit pixel on 8 lines gives bits 15:8, then 7:0.
- R4: With three cycles per pixel (24 bits on 8 lines), the words carry bits 23:16, then 15:8, then 7:0.
- R5: With two pixels in three cycles, the first word is the upper `lines` bits of pixel A. The second word is the remaining half word of A above the top half word of B. The third word is the rest of B.
- R6: If a frame in the fractional layout ends on an unpaired pixel, that pixel's second word is padded with zeros in its lower half.
- R7: After exactly `pix_total` pixels, `frame_done` pulses for one cycle, one cycle after the last word's handshake. A start with a count of zero pulses `frame_done` on the next cycle and sends no words. After reset the block is idle with `frame_done` low.
- R8: `bus_dc` is low for command words and high for parameter words and pixel words.
- R9: While a frame is active, `cmd_ready` stays low. A pending command goes out after the frame ends.
- R10: While `bus_ready` is low during a frame, `bus_valid`, `bus_data` and `bus_dc` hold steady.
- R11: A `start` is ignored while a frame is active or while `cfg_err` is high.
- R12: Data lines above the configured width are driven to 0. Pixel bits above the configured pixel size are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_code | input | 2 | Bus width code |
| pix_code | input | 2 | Pixel size code |
| fmt_code | output | 2 | Decoded cycle format of the live configuration |
| cfg_err | output | 1 | Live configuration is invalid |
| start | input | 1 | Begin a frame (one-cycle pulse) |
| pix_total | input | CNT_W | Pixel count for the frame |
| pix_valid | input | 1 | Pixel available |
| pix_data | input | 24 | Pixel, LSB-aligned |
| pix_ready | output | 1 | Pixel accepted this cycle when valid |
| cmd_valid | input | 1 | Command or parameter word available |
| cmd_is_param | input | 1 | 1 = parameter word, 0 = command word |
| cmd_word | input | 16 | Command or parameter value |
| cmd_ready | output | 1 | Command word taken this cycle when valid |
| bus_valid | output | 1 | Bus word offered to the timing engine |
| bus_ready | input | 1 | Timing engine takes the word |
| bus_data | output | 16 | Bus word, LSB-aligned |
| bus_dc | output | 1 | Data/command select |
| frame_done | output | 1 | One-cycle end-of-frame pulse |

## Verification
A start pulse and a command handshake can land in the same cycle, because the command path goes straight through while the block is idle. The bench raises `start` and `cmd_valid` on the same edge. It expects the command as the first captured word with select low, followed by the complete frame. In a second case, a command is raised while a stalled frame is running. It must not appear until every frame word has gone out and `frame_done` has pulsed.

// File: rtl/pix_bus_packer.sv
module pix_bus_packer #(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       bus_code,
  input  logic [1:0]       pix_code,
  output logic [1:0]       fmt_code,
  output logic             cfg_err,
  input  logic             start,
  input  logic [CNT_W-1:0] pix_total,
  input  logic             pix_valid,
  input  logic [23:0]      pix_data,
  output logic             pix_ready,
  input  logic             cmd_valid,
  input  logic             cmd_is_param,
  input  logic [15:0]      cmd_word,
  output logic             cmd_ready,
  output logic             bus_valid,
  input  logic             bus_ready,
  output logic [15:0]      bus_data,
  output logic             bus_dc,
  output logic             frame_done
);
  localparam int PW = 24;
  localparam int DW = 16;
  localparam int BW = 2 * PW;
  localparam int FW = $clog2(BW + 1);

  logic             active;
  logic [CNT_W-1:0] rem;
  logic [FW-1:0]    fill;
  logic [BW-1:0]    acc;
  logic [4:0]       lanes, psz, live_lanes, live_bits;

  always_comb begin
    case (bus_code)
      2'd0:    live_lanes = 5'd8;
      2'd1:    live_lanes = 5'd9;
      2'd2:    live_lanes = 5'd12;
      default: live_lanes = 5'd16;
    endcase
    case (pix_code)
      2'd0:    live_bits = 5'd12;
      2'd1:    live_bits = 5'd16;
      2'd2:    live_bits = 5'd18;
      default: live_bits = 5'd24;
    endcase
  end

  always_comb begin
    fmt_code = 2'd0;
    cfg_err  = 1'b0;
    case ({bus_code, pix_code})
      4'b00_00: fmt_code = 2'd3;
      4'b00_01: fmt_code = 2'd1;
      4'b00_11: fmt_code = 2'd2;
      4'b01_10: fmt_code = 2'd1;
      4'b10_00: fmt_code = 2'd0;
      4'b10_10: fmt_code = 2'd3;
      4'b10_11: fmt_code = 2'd1;
      4'b11_01: fmt_code = 2'd0;
      4'b11_11: fmt_code = 2'd3;
      default:  cfg_err  = 1'b1;
    endcase
  end

  logic [PW-1:0] pmask;
  logic [BW-1:0] ext;
  logic [FW-1:0] sh, fill_nxt;
  logic [DW-1:0] data_word, cmd_masked, lmask;
  logic          dat_valid, full_word;

  assign pmask      = PW'((25'd1 << psz) - 25'd1);
  assign ext        = {{(BW-PW){1'b0}}, pix_data & pmask};
  assign sh         = FW'(BW) - {1'b0, psz} - fill;
  assign full_word  = fill >= {1'b0, lanes};
  assign fill_nxt   = full_word ? fill - {1'b0, lanes} : '0;
  assign data_word  = acc[BW-1 -: DW] >> (5'(DW) - lanes);
  assign lmask      = DW'((17'd1 << live_lanes) - 17'd1);
  assign cmd_masked = cmd_word & lmask;

  assign pix_ready = active && (rem != '0) && !full_word;
  assign dat_valid = active && (full_word || ((fill != '0) && (rem == '0)));
  assign bus_valid = active ? dat_valid : cmd_valid;
  assign bus_data  = active ? data_word : cmd_masked;
  assign bus_dc    = active ? 1'b1 : cmd_is_param;
  assign cmd_ready = !active && bus_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active     <= 1'b0;
      rem        <= '0;
      fill       <= '0;
      acc        <= '0;
      lanes      <= 5'd8;
      psz        <= 5'd12;
      frame_done <= 1'b0;
    end else begin
      frame_done <= 1'b0;
      if (!active) begin
        if (start && !cfg_err) begin
          if (pix_total == '0) begin
            frame_done <= 1'b1;
          end else begin
            active <= 1'b1;
            rem    <= pix_total;
            lanes  <= live_lanes;
            psz    <= live_bits;
            fill   <= '0;
            acc    <= '0;
          end
        end
      end else if (pix_ready && pix_valid) begin
        acc  <= acc | (ext << sh);
        fill <= fill + {1'b0, psz};
        rem  <= rem - CNT_W'(1);
      end else if (dat_valid && bus_ready) begin
        acc  <= acc << lanes;
        fill <= fill_nxt;
        if ((rem == '0) && (fill_nxt == '0)) begin
          active     <= 1'b0;
          frame_done <= 1'b1;
        end
      end
    end
  end

  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> !active);
  p_cmd_blocked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> !cmd_ready);
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (active && bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_data) && $stable(bus_dc)));
  p_bad_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && start && cfg_err) |=> (!active && !frame_done));
  p_no_overlap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pix_ready |-> !bus_valid);
  p_upper_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (active && bus_valid) |-> ((bus_data >> lanes) == '0));
endmodule

// File: tb/sim_pix_bus_packer.sv
module sim_pix_bus_packer;
  localparam int CW = 20;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, start, pix_valid, pix_ready, cmd_valid, cmd_is_param, cmd_ready;
  logic bus_valid, bus_ready, bus_dc, frame_done, cfg_err;
  logic [1:0] bus_code, pix_code, fmt_code;
  logic [CW-1:0] pix_total;
  logic [23:0] pix_data;
  logic [15:0] cmd_word, bus_data;

  pix_bus_packer #(.CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_code(bus_code), .pix_code(pix_code),
    .fmt_code(fmt_code), .cfg_err(cfg_err), .start(start), .pix_total(pix_total),
    .pix_valid(pix_valid), .pix_data(pix_data), .pix_ready(pix_ready),
    .cmd_valid(cmd_valid), .cmd_is_param(cmd_is_param), .cmd_word(cmd_word),
    .cmd_ready(cmd_ready), .bus_valid(bus_valid), .bus_ready(bus_ready),
    .bus_data(bus_data), .bus_dc(bus_dc), .frame_done(frame_done));

  int n_chk = 0, n_bad = 0;
  logic [23:0] mem [0:15];
  int n_feed = 0, idx = 0, cyc = 0, ncyc = 0;
  bit feed_en = 1'b0, stall = 1'b0;
  logic [15:0] cap [0:63];
  logic capdc [0:63];
  int ncap = 0, ndone = 0, last_hs = 0, done_cyc = 0, hold_err = 0;
  logic prev_stall = 1'b0;
  logic [15:0] prev_word = '0;

  always @(posedge clk) begin
    #2;
    cyc++;
    bus_ready = stall ? ((cyc % 3) != 0) : 1'b1;
    pix_valid = feed_en && (idx < n_feed);
    pix_data  = mem[idx[3:0]];
  end

  always @(negedge clk) begin
    ncyc++;
    if (prev_stall && bus_valid && bus_data != prev_word) hold_err++;
    prev_stall = bus_valid && !bus_ready;
    prev_word  = bus_data;
    if (bus_valid && bus_ready && ncap < 64) begin
      cap[ncap] = bus_data; capdc[ncap] = bus_dc; ncap++; last_hs = ncyc;
    end
    if (pix_valid && pix_ready) idx++;
    if (frame_done) begin ndone++; done_cyc = ncyc; end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int lanes_of(input logic [1:0] c);
    case (c) 2'd0: return 8; 2'd1: return 9; 2'd2: return 12; default: return 16; endcase
  endfunction
  function automatic int bits_of(input logic [1:0] c);
    case (c) 2'd0: return 12; 2'd1: return 16; 2'd2: return 18; default: return 24; endcase
  endfunction

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  task automatic compare_frame(input logic [1:0] bc, input logic [1:0] pc, input int n,
                               input int off, input string req);
    logic sb [0:511];
    int pos = 0, L = lanes_of(bc), P = bits_of(pc), nw;
    for (int i = 0; i < n; i++)
      for (int b = P - 1; b >= 0; b--) begin sb[pos] = mem[i][b]; pos++; end
    nw = (pos + L - 1) / L;
    chk(ncap == nw + off, req, "word count", ncap, nw + off);
    for (int w = 0; w < nw; w++) begin
      logic [15:0] word = '0;
      for (int b = 0; b < L; b++)
        word[L-1-b] = (w * L + b < pos) ? sb[w * L + b] : 1'b0;
      chk(cap[w + off] == word, req, "bus word", int'(cap[w + off]), int'(word));
      chk(capdc[w + off] == 1'b1, "R8", "data select", int'(capdc[w + off]), 1);
    end
    chk(ndone == 1, "R7", "done pulses", ndone, 1);
    chk(done_cyc == last_hs + 1, "R7", "done timing", done_cyc - last_hs, 1);
    chk(idx == n, "R7", "pixels taken", idx, n);
  endtask

  task automatic wait_done();
    for (int k = 0; k < 600 && ndone == 0; k++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic run_frame(input logic [1:0] bc, input logic [1:0] pc, input int n,
                           input bit stl, input bit restart, input string req);
    @(posedge clk); #1;
    bus_code = bc; pix_code = pc; stall = stl;
    ncap = 0; ndone = 0; idx = 0; n_feed = n; feed_en = 1'b1;
    start = 1'b1; pix_total = CW'(n);
    @(posedge clk); #1 start = 1'b0;
    if (restart) begin
      repeat (3) @(posedge clk);
      #1 start = 1'b1; pix_total = CW'(1);
      @(posedge clk); #1 start = 1'b0;
    end
    wait_done();
    feed_en = 1'b0;
    compare_frame(bc, pc, n, 0, req);
  endtask

  task automatic send_cmd(input bit par, input logic [15:0] w);
    @(posedge clk); #1;
    cmd_valid = 1'b1; cmd_is_param = par; cmd_word = w;
    forever begin @(negedge clk); if (cmd_ready) break; end
    @(posedge clk); #1 cmd_valid = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(frame_done == 1'b0, "R7", "reset frame_done", int'(frame_done), 0);
    chk(pix_ready == 1'b0, "R7", "reset pix_ready", int'(pix_ready), 0);
    chk(bus_valid == 1'b0, "R7", "reset bus_valid", int'(bus_valid), 0);
    chk(cmd_ready == 1'b1, "R9", "idle cmd_ready", int'(cmd_ready), 1);
  endtask

  task automatic t_cfg_table();
    for (int b = 0; b < 4; b++)
      for (int p = 0; p < 4; p++) begin
        int L = lanes_of(2'(b)), P = bits_of(2'(p)), ef = 0;
        bit ee = 1'b0;
        @(posedge clk); #1 bus_code = 2'(b); pix_code = 2'(p);
        @(negedge clk);
        if (P % L == 0 && P / L >= 1 && P / L <= 3) ef = P / L - 1;
        else if ((2 * P) % L == 0 && (2 * P) / L == 3) ef = 3;
        else ee = 1'b1;
        chk(cfg_err == ee, "R1", "cfg_err", int'(cfg_err), int'(ee));
        if (!ee) chk(fmt_code == 2'(ef), "R1", "fmt_code", int'(fmt_code), ef);
      end
  endtask

  task automatic t_zero();
    @(posedge clk); #1 bus_code = 2'd3; pix_code = 2'd1; ncap = 0; ndone = 0;
    start = 1'b1; pix_total = '0;
    @(posedge clk); #1 start = 1'b0;
    @(negedge clk);
    chk(frame_done == 1'b1, "R7", "zero count pulse", int'(frame_done), 1);
    repeat (4) @(negedge clk);
    chk(ndone == 1 && ncap == 0, "R7", "zero count words", ncap, 0);
  endtask

  task automatic t_bad_cfg();
    @(posedge clk); #1 bus_code = 2'd1; pix_code = 2'd0; ncap = 0; ndone = 0;
    idx = 0; n_feed = 2; feed_en = 1'b1; start = 1'b1; pix_total = CW'(2);
    @(posedge clk); #1 start = 1'b0;
    repeat (8) @(negedge clk);
    feed_en = 1'b0;
    chk(ncap == 0 && ndone == 0 && idx == 0, "R11", "start with bad cfg", ncap + ndone + idx, 0);
  endtask

  task automatic t_cmds();
    @(posedge clk); #1 bus_code = 2'd0; pix_code = 2'd1; stall = 1'b0; ncap = 0;
    send_cmd(1'b0, 16'h12A5);
    send_cmd(1'b1, 16'h0F3C);
    @(negedge clk);
    chk(ncap == 2, "R8", "cmd count", ncap, 2);
    chk(cap[0] == 16'h00A5, "R12", "cmd masked to 8 lanes", int'(cap[0]), 16'h00A5);
    chk(capdc[0] == 1'b0, "R8", "command select", int'(capdc[0]), 0);
    chk(cap[1] == 16'h003C, "R12", "param masked", int'(cap[1]), 16'h003C);
    chk(capdc[1] == 1'b1, "R8", "parameter select", int'(capdc[1]), 1);
  endtask

  task automatic t_cmd_blocked();
    mem[0] = 24'h00_1111; mem[1] = 24'h00_2222; mem[2] = 24'h00_3333; mem[3] = 24'h00_4444;
    @(posedge clk); #1 bus_code = 2'd0; pix_code = 2'd1; stall = 1'b1;
    ncap = 0; ndone = 0; idx = 0; n_feed = 4; feed_en = 1'b1; start = 1'b1; pix_total = CW'(4);
    @(posedge clk); #1 start = 1'b0;
    fork
      send_cmd(1'b0, 16'h005A);
      wait_done();
    join
    feed_en = 1'b0;
    repeat (2) @(negedge clk);
    chk(ncap == 9, "R9", "words incl. command", ncap, 9);
    chk(cap[8] == 16'h005A && capdc[8] == 1'b0, "R9", "command after frame", int'(cap[8]), 16'h005A);
    chk(cap[7] == 16'h0044, "R9", "frame finished first", int'(cap[7]), 16'h0044);
  endtask

  task automatic t_same_cycle();
    mem[0] = 24'h00_ABCD; mem[1] = 24'h00_0102;
    @(posedge clk); #1 bus_code = 2'd3; pix_code = 2'd1; stall = 1'b0;
    ncap = 0; ndone = 0; idx = 0; n_feed = 2; feed_en = 1'b1;
    start = 1'b1; pix_total = CW'(2);
    cmd_valid = 1'b1; cmd_is_param = 1'b0; cmd_word = 16'h002C;
    @(posedge clk); #1 start = 1'b0; cmd_valid = 1'b0;
    wait_done();
    feed_en = 1'b0;
    chk(cap[0] == 16'h002C && capdc[0] == 1'b0, "R8", "same-cycle command first", int'(cap[0]), 16'h002C);
    compare_frame(2'd3, 2'd1, 2, 1, "R2");
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; pix_total = '0; cmd_valid = 1'b0; cmd_is_param = 1'b0;
    cmd_word = '0; bus_code = 2'd0; pix_code = 2'd0; bus_ready = 1'b1; pix_valid = 1'b0;
    pix_data = '0;
    for (int i = 0; i < 16; i++) mem[i] = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_cfg_table();

    mem[0] = 24'hFF_ABCD; mem[1] = 24'h00_1234; mem[2] = 24'h5A_00FF;
    run_frame(2'd0, 2'd1, 3, 1'b0, 1'b0, "R3");
    chk(cap[0] == 16'h00AB && cap[1] == 16'h00CD, "R3", "high byte first", int'(cap[0]), 16'h00AB);
    run_frame(2'd3, 2'd1, 3, 1'b0, 1'b0, "R2");
    chk(cap[0] == 16'hABCD, "R2", "whole pixel", int'(cap[0]), 16'hABCD);
    mem[0] = 24'h123456; mem[1] = 24'hA1B2C3;
    run_frame(2'd0, 2'd3, 2, 1'b0, 1'b0, "R4");
    chk(cap[0] == 16'h0012 && cap[1] == 16'h0034 && cap[2] == 16'h0056, "R4", "three bytes",
        int'(cap[2]), 16'h0056);
    run_frame(2'd2, 2'd3, 2, 1'b1, 1'b0, "R3");
    mem[0] = 24'h000ABC; mem[1] = 24'h000DEF; mem[2] = 24'h000123; mem[3] = 24'h000456;
    run_frame(2'd0, 2'd0, 4, 1'b0, 1'b0, "R5");
    chk(cap[1] == 16'h00CD, "R5", "shared middle word", int'(cap[1]), 16'h00CD);
    chk(cap[2] == 16'h00EF, "R5", "tail of second pixel", int'(cap[2]), 16'h00EF);
    chk(cap[0][15:8] == 8'h00, "R12", "unused lines low", int'(cap[0][15:8]), 0);
    run_frame(2'd0, 2'd0, 3, 1'b0, 1'b0, "R6");
    chk(cap[4] == 16'h0030, "R6", "padded trailing word", int'(cap[4]), 16'h0030);
    mem[0] = 24'h123456; mem[1] = 24'hFEDCBA;
    hold_err = 0;
    run_frame(2'd3, 2'd3, 2, 1'b1, 1'b0, "R5");
    chk(cap[1] == 16'h56FE, "R5", "16-lane shared word", int'(cap[1]), 16'h56FE);
    mem[0] = 24'h3_1234; mem[1] = 24'h2_ABCD;
    run_frame(2'd1, 2'd2, 2, 1'b1, 1'b0, "R3");
    chk(hold_err == 0, "R10", "words held under stall", hold_err, 0);
    for (int i = 0; i < 6; i++) mem[i] = 24'(32'h0101 * (i + 1));
    run_frame(2'd0, 2'd1, 6, 1'b1, 1'b1, "R11");
    t_zero();
    t_bad_cfg();
    t_cmds();
    t_cmd_blocked();
    t_same_cycle();
    finish_run();
  end
endmodule